// File: doc/BRIEF.md
# OTP Fuse Programming Controller

This block burns one 32-bit word at a time into a one-time-programmable fuse array. Software reaches it through a small register port that is read and written one word at a time. To program a word, software writes the target word index and an unlock key into the control register. It then writes the value to burn into the data register. If the key is correct, the target word is not locked and no earlier error is pending, the controller latches the index and raises BUSY. It reads the word's current fuse contents and drops every bit that is already blown. It then walks the 32 bits from the least significant end and pulses a fuse strobe once for each bit that still has to be burned.

Each burned bit gets a relax interval, then a program strobe, then a second relax interval. The number of clock cycles for each comes from a timing register. While the walk runs, the data register shifts right with zero fill. An attempt on a locked word or on an index outside the array does not touch the fuses, leaves BUSY low and sets a sticky ERROR flag. While ERROR is set, the controller refuses every new attempt until software clears the flag. Set and clear alias addresses let software change control bits without a read-modify-write. A fuse window in the register space reads back the contents of every word. The fuse array is a simple model held inside the block, and a lock input marks the words that may not be programmed.

Top module: `fuse_prog_ctrl`

## Requirements
- R1: After reset, the control, timing and data registers read 0, every fuse word reads 0 and the fuse strobe is low. Register offsets: control 0x000, set alias 0x004, clear alias 0x008, timing 0x010, data 0x020. Fuse word w reads at 0x400 + 4*w. Control fields: word index in bits 6:0, BUSY in bit 8, ERROR in bit 9, reload request in bit 10, key in bits 31:16.
- R2: A write to the set alias ORs the written 1 bits into the index, key, ERROR and reload fields. A write to the clear alias clears them. BUSY cannot be written.
- R3: A data-register write starts programming when all of these hold: the key field holds 0x3E77, BUSY and ERROR are low, and the index names an unlocked word. In that case BUSY reads 1 in the following cycle and the key field reads 0.
- R4: A data-register write made without the correct key changes nothing. BUSY and ERROR stay low, the key is kept, the data register is unchanged and no fuse changes.
- R5: Only bits that are 1 in the written data and still unblown in the target word are strobed. Afterwards the word reads as its old value OR the data, and the fuse strobe has been high for exactly (bits burned) x (program width) cycles.
- R6: The word index is latched when programming starts. Later writes to the index field do not change which word is burned.
- R7: When the blown-bit read finishes, the data register holds the masked data. It then shifts right one place per bit, with zero fill, and reads 0 at the end. Data-register writes made while BUSY is high are ignored.
- R8: An attempt with a valid key on a locked word, or on an index at or above the word count, sets ERROR, clears the key, leaves BUSY low and changes no fuse.
- R9: While ERROR is set, a keyed data write is ignored and the key is kept. After ERROR is cleared through the clear alias, a keyed data write is accepted again.
- R10: The timing register holds the program width in bits 11:0, the relax width in bits 15:12 and the read width in bits 21:16. Other bits read 0. BUSY stays high for read + 32 + n x (2 x relax + program) cycles, where n is the number of bits burned and any width of 0 counts as 1.
- R11: The fuse strobe is high only while BUSY is high, and each strobe pulse lasts exactly the program width.
- R12: A reload request written as 1 reads back as 1 for one cycle and then clears itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| word_lock | input | NUM_WORDS | One bit per fuse word; 1 forbids programming that word |
| fuse_strobe | output | 1 | Program strobe to the fuse array |
| fuse_word | output | 7 | Latched word index under programming |
| fuse_bit | output | 5 | Bit position under programming |

## Verification
The hardest case to reach from the ports is a data word whose bits are partly blown already. Masking and bit skipping only show up when a second burn lands on a word that already holds an earlier value. The stimulus therefore sweeps every word index twice, once on fresh fuses and once with a rotated pattern. It also takes a dedicated word through a pre-burn, then samples the data register cycle by cycle after the restart to catch the masked and shifted values. The sweep includes the locked word and out-of-range indices, and each of those must take the error path and then be cleared.

// File: rtl/fuse_prog_pkg.sv
// Shared constants and types for the fuse programming controller.
// Assumes a 32-bit register port and 32-bit fuse words.
package fuse_prog_pkg;
    localparam int WORD_W = 32;
    localparam int BIT_W  = 5;

    localparam logic [11:0] OFS_CTRL   = 12'h000;
    localparam logic [11:0] OFS_SET    = 12'h004;
    localparam logic [11:0] OFS_CLR    = 12'h008;
    localparam logic [11:0] OFS_TIMING = 12'h010;
    localparam logic [11:0] OFS_DATA   = 12'h020;

    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ_MASK, ST_SETUP, ST_STROBE, ST_HOLD, ST_NEXT_BIT
    } seq_state_t;

    typedef struct packed {
        logic [5:0]  rd_width;
        logic [3:0]  relax_width;
        logic [11:0] prog_width;
    } timing_t;
endpackage

// File: rtl/fuse_array_model.sv
// Behavioural fuse array: NUM_WORDS words of WORD_W one-time bits.
// A cell is set to 1 on any cycle where burn_en is high for it and never
// returns to 0 except by reset. Assumes burn_word is always in range.
module fuse_array_model
    import fuse_prog_pkg::*;
#(
    parameter int NUM_WORDS = 16,
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        burn_en,
    input  logic [IDX_W-1:0]            burn_word,
    input  logic [BIT_W-1:0]            burn_bit,
    output logic [NUM_WORDS*WORD_W-1:0] cells_o
);
    logic [WORD_W-1:0] mem_q [NUM_WORDS];

    // Burn the addressed cell; the array clears only on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WORDS; w++) mem_q[w] <= '0;
        end else if (burn_en) begin
            mem_q[burn_word][burn_bit] <= 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_flat
        assign cells_o[g*WORD_W +: WORD_W] = mem_q[g];
    end
endmodule

// File: rtl/fuse_prog_seq.sv
// Programming sequencer. On start it latches the word index and data, waits
// the read width, masks out bits already blown, then visits all 32 bits from
// the LSB. Each bit to burn gets relax, strobe and relax intervals; zero bits
// cost one cycle. The data register shifts right once per visited bit.
// Assumes the timing fields stay stable while busy.
module fuse_prog_seq
    import fuse_prog_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [IDX_W-1:0]   start_word,
    input  logic [WORD_W-1:0]  start_data,
    input  timing_t            tm,
    input  logic [WORD_W-1:0]  cur_fuse,
    output logic               busy,
    output logic               strobe,
    output logic [IDX_W-1:0]   word_q,
    output logic [BIT_W-1:0]   bit_q,
    output logic [WORD_W-1:0]  data_q
);
    seq_state_t        state_q;
    logic [11:0]       cnt_q;
    logic [11:0]       limit;
    logic              done;
    logic [WORD_W-1:0] masked;

    // Select the length of the current timed state.
    always_comb begin
        case (state_q)
            ST_READ_MASK: limit = {6'b0, tm.rd_width};
            ST_SETUP,
            ST_HOLD:      limit = {8'b0, tm.relax_width};
            ST_STROBE:    limit = tm.prog_width;
            default:      limit = 12'd0;
        endcase
    end

    assign done   = ({1'b0, cnt_q} + 13'd1) >= {1'b0, limit};
    assign masked = data_q & ~cur_fuse;
    assign busy   = (state_q != ST_IDLE);
    assign strobe = (state_q == ST_STROBE);

    // Advance the state machine, cycle counter, bit index and data shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            word_q  <= '0;
            bit_q   <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    data_q  <= start_data;
                    word_q  <= start_word;
                    bit_q   <= '0;
                    cnt_q   <= '0;
                    state_q <= ST_READ_MASK;
                end
                ST_READ_MASK: if (done) begin
                    data_q  <= masked;
                    cnt_q   <= '0;
                    state_q <= masked[0] ? ST_SETUP : ST_NEXT_BIT;
                end else cnt_q <= cnt_q + 12'd1;
                ST_SETUP: if (done) begin
                    cnt_q   <= '0;
                    state_q <= ST_STROBE;
                end else cnt_q <= cnt_q + 12'd1;
                ST_STROBE: if (done) begin
                    cnt_q   <= '0;
                    state_q <= ST_HOLD;
                end else cnt_q <= cnt_q + 12'd1;
                ST_HOLD: if (done) begin
                    cnt_q   <= '0;
                    state_q <= ST_NEXT_BIT;
                end else cnt_q <= cnt_q + 12'd1;
                ST_NEXT_BIT: begin
                    data_q <= data_q >> 1;
                    cnt_q  <= '0;
                    if (bit_q == BIT_W'(WORD_W - 1)) begin
                        state_q <= ST_IDLE;
                    end else begin
                        bit_q   <= bit_q + 1'b1;
                        state_q <= data_q[1] ? ST_SETUP : ST_NEXT_BIT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fuse_prog_ctrl.sv
// Top of the fuse programming controller: register decode, control and
// timing registers, key and lock checks, sticky error, and the fuse window.
// Assumes one register access per cycle and NUM_WORDS of at most 128.
module fuse_prog_ctrl
    import fuse_prog_pkg::*;
#(
    parameter int NUM_WORDS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [11:0]          reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_WORDS-1:0] word_lock,
    output logic                 fuse_strobe,
    output logic [6:0]           fuse_word,
    output logic [4:0]           fuse_bit
);
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam logic [7:0] NW8 = 8'(NUM_WORDS);

    logic [6:0]  addr_q;
    logic [15:0] key_q;
    logic        err_q;
    logic        reload_q;
    timing_t     tim_q;

    logic seq_busy, seq_strobe;
    logic [IDX_W-1:0]  lat_word;
    logic [BIT_W-1:0]  bit_idx;
    logic [WORD_W-1:0] data_q;
    logic [NUM_WORDS*WORD_W-1:0] cells;

    logic wr_ctrl, wr_set, wr_clr, wr_tim, wr_data;
    logic locked, attempt, start, reject;
    logic [IDX_W-1:0] win_idx;
    logic unused_wdata;

    assign wr_ctrl = reg_we && reg_addr == OFS_CTRL;
    assign wr_set  = reg_we && reg_addr == OFS_SET;
    assign wr_clr  = reg_we && reg_addr == OFS_CLR;
    assign wr_tim  = reg_we && reg_addr == OFS_TIMING;
    assign wr_data = reg_we && reg_addr == OFS_DATA;

    // Decide whether the selected word may be programmed.
    always_comb begin
        if ({1'b0, addr_q} < NW8) locked = word_lock[addr_q[IDX_W-1:0]];
        else                      locked = 1'b1;
    end

    assign attempt = wr_data && !seq_busy && !err_q && key_q == UNLOCK_KEY;
    assign start   = attempt && !locked;
    assign reject  = attempt && locked;

    // Control register with set/clear aliases, key consumption and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            key_q    <= '0;
            err_q    <= 1'b0;
            reload_q <= 1'b0;
        end else begin
            reload_q <= 1'b0;
            if (wr_ctrl) begin
                addr_q   <= reg_wdata[6:0];
                key_q    <= reg_wdata[31:16];
                reload_q <= reg_wdata[10];
            end
            if (wr_set) begin
                addr_q   <= addr_q | reg_wdata[6:0];
                key_q    <= key_q | reg_wdata[31:16];
                err_q    <= err_q | reg_wdata[9];
                reload_q <= reg_wdata[10];
            end
            if (wr_clr) begin
                addr_q <= addr_q & ~reg_wdata[6:0];
                key_q  <= key_q & ~reg_wdata[31:16];
                err_q  <= err_q & ~reg_wdata[9];
            end
            if (attempt) key_q <= '0;
            if (reject)  err_q <= 1'b1;
        end
    end

    // Timing register holding the three pulse widths.
    always_ff @(posedge clk) begin
        if (!rst_n)      tim_q <= '0;
        else if (wr_tim) tim_q <= reg_wdata[21:0];
    end

    assign unused_wdata = ^{reg_wdata[15:11], reg_wdata[8]};

    fuse_prog_seq #(.IDX_W(IDX_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_word (addr_q[IDX_W-1:0]),
        .start_data (reg_wdata),
        .tm         (tim_q),
        .cur_fuse   (cells[{lat_word, 5'b0} +: WORD_W]),
        .busy       (seq_busy),
        .strobe     (seq_strobe),
        .word_q     (lat_word),
        .bit_q      (bit_idx),
        .data_q     (data_q)
    );

    fuse_array_model #(.NUM_WORDS(NUM_WORDS)) fuse_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .burn_en   (seq_strobe),
        .burn_word (lat_word),
        .burn_bit  (bit_idx),
        .cells_o   (cells)
    );

    assign win_idx = reg_addr[IDX_W+1:2];

    // Register read multiplexer including the fuse readback window.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL, OFS_SET, OFS_CLR:
                reg_rdata = {key_q, 5'b0, reload_q, err_q, seq_busy, 1'b0, addr_q};
            OFS_TIMING: reg_rdata = {10'b0, tim_q};
            OFS_DATA:   reg_rdata = data_q;
            default:
                if (reg_addr[11:10] == 2'b01 && reg_addr[1:0] == 2'b00 && reg_addr[9:2] < NW8)
                    reg_rdata = cells[{win_idx, 5'b0} +: WORD_W];
        endcase
    end

    assign fuse_strobe = seq_strobe;
    assign fuse_word   = 7'(lat_word);
    assign fuse_bit    = bit_idx;
endmodule

// File: rtl/fuse_prog_checker.sv
// Property checker for fuse_prog_ctrl, bound to every instance of the top.
// Observes the register port, lock input, sequencer state and fuse cells.
module fuse_prog_checker
    import fuse_prog_pkg::*;
#(
    parameter int NUM_WORDS = 16,
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_we,
    input logic [11:0]                 reg_addr,
    input logic [NUM_WORDS-1:0]        word_lock,
    input logic                        busy,
    input logic                        err,
    input logic [15:0]                 key,
    input logic                        reload,
    input logic [6:0]                  addr,
    input logic                        strobe,
    input logic [IDX_W-1:0]            lat_word,
    input logic [NUM_WORDS*WORD_W-1:0] cells
);
    logic data_wr, tgt_locked;
    assign data_wr    = reg_we && reg_addr == OFS_DATA;
    assign tgt_locked = ({1'b0, addr} >= 8'(NUM_WORDS)) || word_lock[addr[IDX_W-1:0]];

    p_key_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> key == 16'h0);

    p_nokey_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && !busy && key != UNLOCK_KEY |=> !busy && err == $past(err));

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_mono
        p_fuse_monotonic_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cells[g*WORD_W +: WORD_W] & $past(cells[g*WORD_W +: WORD_W]))
                == $past(cells[g*WORD_W +: WORD_W]));
    end

    p_latch_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> lat_word == $past(lat_word));

    p_lock_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && !busy && !err && key == UNLOCK_KEY && tgt_locked |=> err && !busy);

    p_error_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && !busy && err |=> !busy);

    p_strobe_inside_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> busy);

    p_reload_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        reload && !reg_we |=> !reload);
endmodule

bind fuse_prog_ctrl fuse_prog_checker #(.NUM_WORDS(NUM_WORDS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .word_lock (word_lock),
    .busy      (seq_busy),
    .err       (err_q),
    .key       (key_q),
    .reload    (reload_q),
    .addr      (addr_q),
    .strobe    (fuse_strobe),
    .lat_word  (lat_word),
    .cells     (cells)
);

// File: tb/fuse_prog_ctrl_tb_top.sv
`timescale 1ns/1ps
module fuse_prog_ctrl_tb_top;
    localparam int NW = 8;
    localparam logic [11:0] A_CTRL = 12'h000, A_SET = 12'h004, A_CLR = 12'h008;
    localparam logic [11:0] A_TIM = 12'h010, A_DATA = 12'h020, A_FUSE = 12'h400;
    localparam logic [15:0] KEY = 16'h3E77;
    localparam int T_PROG = 3, T_RELAX = 2, T_RD = 2;
    localparam logic [NW-1:0] LOCKS = 8'b0010_0000;

    logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic fuse_strobe;
    logic [6:0] fuse_word;
    logic [4:0] fuse_bit;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [31:0] ref_fuse [NW];

    always #4 clk = ~clk;

    fuse_prog_ctrl #(.NUM_WORDS(NW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .word_lock(LOCKS),
        .fuse_strobe(fuse_strobe), .fuse_word(fuse_word), .fuse_bit(fuse_bit));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    function automatic logic [11:0] fa(input int w);
        return A_FUSE + 12'(4 * w);
    endfunction

    // Sample busy and strobe at each negedge until idle; checks pulse lengths (R11).
    task automatic wait_idle(output int bc, output int sc);
        logic [31:0] v;
        int run;
        bc = 0; sc = 0; run = 0;
        for (int i = 0; i < 5000; i++) begin
            rd(A_CTRL, v);
            if (!v[8]) break;
            bc++;
            if (fuse_strobe) begin sc++; run++; end
            else if (run != 0) begin chk("R11 strobe pulse width", run, T_PROG); run = 0; end
            @(negedge clk);
        end
    endtask

    // One programming attempt with full expectation bookkeeping.
    task automatic burn(input int w, input logic [31:0] d);
        logic [31:0] v, nb;
        int bc, sc;
        bit lk;
        lk = (w >= NW) || LOCKS[w % NW];
        wr(A_CTRL, {KEY, 9'b0, 7'(w)});
        wr(A_DATA, d);
        rd(A_CTRL, v);
        if (lk) begin
            chk("R8 error set, busy low, key cleared", {v[31:16], 6'b0, v[9:8]}, {16'h0, 6'b0, 2'b10});
            if (w < NW) begin rd(fa(w), v); chk("R8 locked word untouched", v, ref_fuse[w]); end
            wr(A_CLR, 32'h0000_0200);
            rd(A_CTRL, v);
            chk("R9 error cleared by clear alias", {31'b0, v[9]}, 32'h0);
        end else begin
            chk("R3 busy raised and key consumed", {v[31:16], 7'b0, v[8]}, {16'h0, 7'b0, 1'b1});
            nb = d & ~ref_fuse[w];
            wait_idle(bc, sc);
            chk("R10 busy duration", bc, T_RD + 32 + $countones(nb) * (2 * T_RELAX + T_PROG));
            chk("R5 strobe cycles", sc, $countones(nb) * T_PROG);
            ref_fuse[w] = ref_fuse[w] | d;
            rd(fa(w), v);
            chk("R5 word after burn", v, ref_fuse[w]);
            rd(A_DATA, v);
            chk("R7 data shifted out", v, 32'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, d1;
        int bc, sc;
        for (int w = 0; w < NW; w++) ref_fuse[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl reset", v, 32'h0);
        rd(A_TIM, v);  chk("R1 timing reset", v, 32'h0);
        rd(A_DATA, v); chk("R1 data reset", v, 32'h0);
        for (int w = 0; w < NW; w++) begin rd(fa(w), v); chk("R1 fuse reset", v, 32'h0); end
        chk("R1 strobe low", {31'b0, fuse_strobe}, 32'h0);

        // R10 timing register layout
        wr(A_TIM, 32'hFFFF_FFFF);
        rd(A_TIM, v); chk("R10 timing readback mask", v, 32'h003F_FFFF);
        wr(A_TIM, {10'b0, 6'(T_RD), 4'(T_RELAX), 12'(T_PROG)});
        rd(A_TIM, v); chk("R10 timing fields", v, 32'h0002_2003);

        // R2 aliases
        wr(A_CTRL, 32'h0);
        wr(A_SET, 32'h3E77_0005); rd(A_CTRL, v); chk("R2 set alias", v, 32'h3E77_0005);
        wr(A_SET, 32'h0000_0002); rd(A_CTRL, v); chk("R2 set alias OR", v, 32'h3E77_0007);
        wr(A_CLR, 32'h0000_0001); rd(A_CTRL, v); chk("R2 clear alias", v, 32'h3E77_0006);
        wr(A_CLR, 32'hFFFF_0000); rd(A_CTRL, v); chk("R2 clear key", v, 32'h0000_0006);
        wr(A_SET, 32'h0000_0300); rd(A_CTRL, v); chk("R2 set error, busy not writable", v, 32'h0000_0206);
        wr(A_CLR, 32'h0000_0200); rd(A_CTRL, v); chk("R2 clear error", v, 32'h0000_0006);

        // R12 reload request self-clears
        wr(A_SET, 32'h0000_0400);
        rd(A_CTRL, v); chk("R12 reload visible", {31'b0, v[10]}, 32'h1);
        @(negedge clk);
        rd(A_CTRL, v); chk("R12 reload cleared", {31'b0, v[10]}, 32'h0);

        // R4 data write without key
        wr(A_CTRL, 32'h1234_0003);
        wr(A_DATA, 32'hFFFF_FFFF);
        rd(A_CTRL, v); chk("R4 no-key ignored", v, 32'h1234_0003);
        rd(A_DATA, v); chk("R4 data unchanged", v, 32'h0);
        @(negedge clk);
        rd(fa(3), v); chk("R4 fuse unchanged", v, 32'h0);

        // R5/R7/R6 masking, shifting and address latch on word 2
        burn(2, 32'h0000_00F0);
        wr(A_CTRL, {KEY, 16'h0002});
        wr(A_DATA, 32'h0000_0FF0);
        rd(A_DATA, v); chk("R7 data loaded", v, 32'h0000_0FF0);
        @(negedge clk); @(negedge clk);
        rd(A_DATA, v); chk("R5 masked data", v, 32'h0000_0F00);
        @(negedge clk);
        rd(A_DATA, v); chk("R7 first shift", v, 32'h0000_0780);
        wr(A_CTRL, 32'h0000_0004);
        wr(A_DATA, 32'hFFFF_FFFF);
        rd(A_DATA, v); chk("R7 write ignored while busy", v, 32'h0000_0078);
        wait_idle(bc, sc);
        chk("R5 strobe cycles after mask", sc, 4 * T_PROG);
        ref_fuse[2] = 32'h0000_0FF0;
        rd(fa(2), v); chk("R6 latched word burned", v, 32'h0000_0FF0);
        rd(fa(4), v); chk("R6 other word untouched", v, 32'h0);
        rd(A_CTRL, v); chk("R6 index field updated", {25'b0, v[6:0]}, 32'h4);

        // R9 error blocks access until cleared
        wr(A_CTRL, {KEY, 16'h0005});
        wr(A_DATA, 32'h1);
        wr(A_CTRL, {KEY, 16'h0001});
        wr(A_DATA, 32'h0000_0011);
        rd(A_CTRL, v); chk("R9 blocked while error", v, {KEY, 16'h0201});
        wr(A_CLR, 32'h0000_0200);
        wr(A_DATA, 32'h0000_0011);
        rd(A_CTRL, v); chk("R9 accepted after clear", {31'b0, v[8]}, 32'h1);
        wait_idle(bc, sc);
        ref_fuse[1] = 32'h0000_0011;
        rd(fa(1), v); chk("R9 burn after clear", v, 32'h0000_0011);

        // Sweep every word twice plus out-of-range indices
        for (int w = 0; w < NW; w++) begin
            d1 = (32'(w) * 32'h9E37_79B1) ^ 32'h0F0F_00FF;
            burn(w, d1);
            burn(w, {d1[23:0], d1[31:24]});
        end
        burn(7, 32'h0);
        burn(0, 32'hFFFF_FFFF);
        burn(8, 32'hFFFF_FFFF);
        burn(127, 32'h1);
        for (int w = 0; w < NW; w++) begin rd(fa(w), v); chk("R5 final fuse image", v, ref_fuse[w]); end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule